// File: doc/BRIEF.md
# CAN Standard Identifier Acceptance Filter

This block sits behind a CAN frame receiver and decides, for each completed frame, whether software should see it. The receiver hands over the 11-bit standard identifier and the 4-bit data length code as one transfer on a valid/ready stream. The block compares the seven most significant identifier bits against a programmable match value. It accepts the frame on an exact match, or unconditionally when the bypass control bit is set.

On acceptance it raises a one-cycle accept pulse. It also stores the four identifier bits that were not compared, together with the data length code, in a read-only status byte, so that software can finish filtering on the low bits. A small byte-wide register port gives access to the status byte, the match value and the control bit. The frame input never back-pressures. `frm_ready` follows the reset input and is high whenever the block is out of reset, so a transfer happens in every cycle where `frm_valid` and `frm_ready` are both high.

Top module: `can_id_filter`

## Requirements
- R1: `frm_ready` is low while `rst_n` is low and high whenever `rst_n` is high; a frame transfers in each cycle with `frm_valid` and `frm_ready` both high.
- R2: With the bypass bit at 0, a transferred frame is accepted exactly when identifier bits 10..4 equal match register bits 6..0.
- R3: With the bypass bit at 1, every transferred frame is accepted, whatever its identifier.
- R4: `acc_pulse` is high in the cycle after an accepted transfer, for that one cycle, and is low in every cycle that does not follow an accepted transfer; back-to-back accepted transfers give back-to-back pulses.
- R5: On an accepted frame, the status byte (register address 0) becomes identifier bits 3..0 in bits 7..4 and the data length code in bits 3..0, and it is readable in the same cycle as the accept pulse.
- R6: A rejected frame leaves the status byte unchanged.
- R7: The status byte is read-only: a write to address 0 leaves its contents unchanged.
- R8: The match register at address 1 is read/write in bits 6..0; bit 7 always reads 0, whatever was written.
- R9: The control register at address 2 holds the bypass bit in bit 0, and its other bits read 0; address 3 reads 0.
- R10: Reset clears the status byte, the match register and the bypass bit, and holds `acc_pulse` low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| frm_valid | input | 1 | A completed frame is offered |
| frm_ready | output | 1 | Block can take a frame (high out of reset) |
| frm_id | input | 11 | Received standard identifier |
| frm_dlc | input | 4 | Received data length code |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 2 | Register address: 0 status, 1 match, 2 control |
| cfg_wdata | input | 8 | Register write data |
| cfg_rdata | output | 8 | Register read data (combinational from address) |
| acc_pulse | output | 1 | One-cycle pulse for each accepted frame |

## Verification
The main sweep offers every one of the 128 upper-identifier values against several match values: all zeros, all ones, and two alternating patterns. In each case exactly one identifier must pass, which separates an exact compare from one that ignores bits or inverts them. The low identifier bits and the length code change with every frame, so a status byte that updates on a rejected frame, or packs the fields in the wrong order, shows up at once. The same sweep is repeated with bypass set, where every frame must pass. Back-to-back transfers separate a per-transfer pulse from a stretched or merged one. Writes of all ones to every address expose reserved bits that are stored when they should not be, and a status byte that software can write.

// File: rtl/canf_pkg.sv
package canf_pkg;

  typedef enum logic [1:0] {
    REG_STAT  = 2'd0,
    REG_MATCH = 2'd1,
    REG_CTRL  = 2'd2,
    REG_NONE  = 2'd3
  } canf_reg_e;

  localparam int CTRL_BYP_BIT = 0;

endpackage

// File: rtl/canf_regs.sv
module canf_regs
  import canf_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int CMP_W  = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [1:0]        addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [DATA_W-1:0] stat_in,
  output logic [DATA_W-1:0] rdata,
  output logic [CMP_W-1:0]  match_q,
  output logic              byp_q
);

  localparam int PAD_W = DATA_W - CMP_W;

  canf_reg_e sel;
  logic      unused_wbits;

  assign sel          = canf_reg_e'(addr);
  assign unused_wbits = ^wdata[DATA_W-1:CMP_W];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      match_q <= '0;
      byp_q   <= 1'b0;
    end else if (we) begin
      case (sel)
        REG_MATCH: match_q <= wdata[CMP_W-1:0];
        REG_CTRL:  byp_q   <= wdata[CTRL_BYP_BIT];
        default:   ;
      endcase
    end
  end

  always_comb begin
    rdata = '0;
    case (sel)
      REG_STAT:  rdata = stat_in;
      REG_MATCH: rdata = {{PAD_W{1'b0}}, match_q};
      REG_CTRL:  rdata[CTRL_BYP_BIT] = byp_q;
      default:   rdata = '0;
    endcase
  end

endmodule

// File: rtl/canf_match.sv
module canf_match #(
  parameter int CMP_W = 7
) (
  input  logic [CMP_W-1:0] id_hi,
  input  logic [CMP_W-1:0] match,
  input  logic             byp,
  output logic             hit
);

  logic [CMP_W-1:0] bit_eq;

  for (genvar i = 0; i < CMP_W; i++) begin : g_cmp
    assign bit_eq[i] = ~(id_hi[i] ^ match[i]);
  end

  assign hit = byp | (&bit_eq);

endmodule

// File: rtl/canf_capture.sv
module canf_capture #(
  parameter int LOW_W  = 4,
  parameter int DLC_W  = 4,
  parameter int DATA_W = LOW_W + DLC_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              xfer,
  input  logic              hit,
  input  logic [LOW_W-1:0]  id_lo,
  input  logic [DLC_W-1:0]  dlc,
  output logic              acc_pulse,
  output logic [DATA_W-1:0] stat_q
);

  logic take;

  assign take = xfer & hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_pulse <= 1'b0;
      stat_q    <= '0;
    end else begin
      acc_pulse <= take;
      if (take) stat_q <= {id_lo, dlc};
    end
  end

endmodule

// File: rtl/can_id_filter.sv
module can_id_filter #(
  parameter int ID_W   = 11,
  parameter int CMP_W  = 7,
  parameter int DLC_W  = 4,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frm_valid,
  output logic              frm_ready,
  input  logic [ID_W-1:0]   frm_id,
  input  logic [DLC_W-1:0]  frm_dlc,
  input  logic              cfg_we,
  input  logic [1:0]        cfg_addr,
  input  logic [DATA_W-1:0] cfg_wdata,
  output logic [DATA_W-1:0] cfg_rdata,
  output logic              acc_pulse
);

  localparam int LOW_W = ID_W - CMP_W;

  logic [CMP_W-1:0]  match_q;
  logic              byp_q;
  logic [DATA_W-1:0] stat_q;
  logic              hit;
  logic              xfer;

  assign frm_ready = rst_n;
  assign xfer      = frm_valid & frm_ready;

  canf_regs #(.DATA_W(DATA_W), .CMP_W(CMP_W)) u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .we      (cfg_we),
    .addr    (cfg_addr),
    .wdata   (cfg_wdata),
    .stat_in (stat_q),
    .rdata   (cfg_rdata),
    .match_q (match_q),
    .byp_q   (byp_q)
  );

  canf_match #(.CMP_W(CMP_W)) u_match (
    .id_hi (frm_id[ID_W-1 -: CMP_W]),
    .match (match_q),
    .byp   (byp_q),
    .hit   (hit)
  );

  canf_capture #(.LOW_W(LOW_W), .DLC_W(DLC_W), .DATA_W(DATA_W)) u_cap (
    .clk       (clk),
    .rst_n     (rst_n),
    .xfer      (xfer),
    .hit       (hit),
    .id_lo     (frm_id[LOW_W-1:0]),
    .dlc       (frm_dlc),
    .acc_pulse (acc_pulse),
    .stat_q    (stat_q)
  );

endmodule

// File: rtl/can_id_filter_chk.sv
module can_id_filter_chk #(
  parameter int ID_W   = 11,
  parameter int CMP_W  = 7,
  parameter int DLC_W  = 4,
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              frm_valid,
  input logic              frm_ready,
  input logic [ID_W-1:0]   frm_id,
  input logic [DLC_W-1:0]  frm_dlc,
  input logic [1:0]        cfg_addr,
  input logic [DATA_W-1:0] cfg_rdata,
  input logic              acc_pulse,
  input logic [CMP_W-1:0]  match_q,
  input logic              byp_q,
  input logic [DATA_W-1:0] stat_q
);

  localparam int LOW_W = ID_W - CMP_W;

  AST_PULSE_NEEDS_XFER: assert property (@(posedge clk) disable iff (!rst_n)
    acc_pulse |-> $past(frm_valid && frm_ready)); // R4

  AST_FILTER_COMPARE: assert property (@(posedge clk) disable iff (!rst_n)
    (frm_valid && frm_ready && !byp_q) |=>
      (acc_pulse == ($past(frm_id[ID_W-1 -: CMP_W]) == $past(match_q)))); // R2

  AST_BYPASS_ALL: assert property (@(posedge clk) disable iff (!rst_n)
    (frm_valid && frm_ready && byp_q) |=> acc_pulse); // R3

  AST_STATUS_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    acc_pulse |-> (stat_q == {$past(frm_id[LOW_W-1:0]), $past(frm_dlc)})); // R5

  AST_STATUS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_pulse |-> $stable(stat_q)); // R6

  AST_MATCH_TOP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_addr == 2'd1) |-> (cfg_rdata[DATA_W-1] == 1'b0)); // R8

endmodule

bind can_id_filter can_id_filter_chk #(
  .ID_W(ID_W), .CMP_W(CMP_W), .DLC_W(DLC_W), .DATA_W(DATA_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .frm_valid (frm_valid),
  .frm_ready (frm_ready),
  .frm_id    (frm_id),
  .frm_dlc   (frm_dlc),
  .cfg_addr  (cfg_addr),
  .cfg_rdata (cfg_rdata),
  .acc_pulse (acc_pulse),
  .match_q   (match_q),
  .byp_q     (byp_q),
  .stat_q    (stat_q)
);

// File: tb/sim_can_id_filter.sv
module sim_can_id_filter;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        frm_valid = 1'b0;
  logic        frm_ready;
  logic [10:0] frm_id = '0;
  logic [3:0]  frm_dlc = '0;
  logic        cfg_we = 1'b0;
  logic [1:0]  cfg_addr = '0;
  logic [7:0]  cfg_wdata = '0;
  logic [7:0]  cfg_rdata;
  logic        acc_pulse;

  int errors = 0;
  int checks = 0;
  logic [7:0] exp_stat = '0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  can_id_filter u0 (
    .clk(clk), .rst_n(rst_n), .frm_valid(frm_valid), .frm_ready(frm_ready),
    .frm_id(frm_id), .frm_dlc(frm_dlc), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .acc_pulse(acc_pulse)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    cfg_addr = a;
    #1;
    d = cfg_rdata;
  endtask

  // Offer one frame; on return the cycle after the transfer is current.
  task automatic send(input logic [10:0] id, input logic [3:0] dlc, input bit byp,
                      input logic [6:0] m, input string req);
    logic [7:0] r;
    bit exp_acc;
    @(negedge clk);
    frm_valid = 1'b1; frm_id = id; frm_dlc = dlc;
    @(negedge clk);
    frm_valid = 1'b0;
    exp_acc = byp || (id[10:4] == m);
    if (exp_acc) exp_stat = {id[3:0], dlc};
    chk({req, " accept"}, {7'd0, acc_pulse}, {7'd0, exp_acc});
    rd(2'd0, r);
    chk(exp_acc ? "R5 status load" : "R6 status hold", r, exp_stat);
  endtask

  initial begin
    logic [7:0] r;
    logic [6:0] mlist [4];
    mlist[0] = 7'h00; mlist[1] = 7'h7F; mlist[2] = 7'h55; mlist[3] = 7'h2A;

    #(CLK_PERIOD*2 + 1);
    chk("R1 ready in reset", {7'd0, frm_ready}, 8'h00);
    chk("R10 pulse in reset", {7'd0, acc_pulse}, 8'h00);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk("R1 ready after reset", {7'd0, frm_ready}, 8'h01);
    rd(2'd0, r); chk("R10 status reset", r, 8'h00);
    rd(2'd1, r); chk("R10 match reset", r, 8'h00);
    rd(2'd2, r); chk("R10 bypass reset", r, 8'h00);

    wr(2'd1, 8'hFF);
    rd(2'd1, r); chk("R8 match bit7 zero", r, 8'h7F);
    wr(2'd2, 8'hFF);
    rd(2'd2, r); chk("R9 ctrl reserved zero", r, 8'h01);
    wr(2'd3, 8'hFF);
    rd(2'd3, r); chk("R9 addr3 zero", r, 8'h00);
    wr(2'd0, 8'hA5);
    rd(2'd0, r); chk("R7 status read-only", r, 8'h00);
    wr(2'd2, 8'h00);

    for (int b = 0; b < 2; b++) begin
      wr(2'd2, {7'd0, b[0]});
      for (int mi = 0; mi < 4; mi++) begin
        wr(2'd1, {1'b0, mlist[mi]});
        rd(2'd1, r); chk("R8 match readback", r, {1'b0, mlist[mi]});
        for (int h = 0; h < 128; h++) begin
          logic [3:0] lo;
          logic [3:0] dl;
          lo = 4'((h * 5 + mi * 3 + b) & 15);
          dl = 4'((h * 7 + mi + 2 * b + 1) & 15);
          send({h[6:0], lo}, dl, b[0], mlist[mi], b ? "R3" : "R2");
        end
        wr(2'd0, 8'h3C);
        rd(2'd0, r); chk("R7 status write ignored", r, exp_stat);
      end
    end

    // Back-to-back transfers with bypass set.
    wr(2'd2, 8'h01);
    @(negedge clk);
    frm_valid = 1'b1; frm_id = 11'h12A; frm_dlc = 4'h3;
    @(negedge clk);
    frm_id = 11'h3F5; frm_dlc = 4'hC;
    #1;
    chk("R4 first pulse", {7'd0, acc_pulse}, 8'h01);
    rd(2'd0, r); chk("R5 first status", r, 8'hA3);
    @(negedge clk);
    frm_valid = 1'b0;
    #1;
    chk("R4 second pulse", {7'd0, acc_pulse}, 8'h01);
    rd(2'd0, r); chk("R5 second status", r, 8'h5C);
    @(negedge clk);
    chk("R4 pulse ends", {7'd0, acc_pulse}, 8'h00);
    @(negedge clk);
    chk("R4 idle no pulse", {7'd0, acc_pulse}, 8'h00);

    // Reset clears state written earlier.
    rst_n = 1'b0;
    #1;
    rd(2'd0, r); chk("R10 status cleared", r, 8'h00);
    rd(2'd1, r); chk("R10 match cleared", r, 8'h00);
    rd(2'd2, r); chk("R10 bypass cleared", r, 8'h00);
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (150000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=finish");
      end
    join_any
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule